// File: doc/BRIEF.md
# Shared Reset/Interrupt Entry Sequencer

This block is the entry controller of an 8-bit processor core. It runs one fixed seven-cycle micro-sequence that serves three different causes: leaving reset, a hardware interrupt request, and the software break opcode (0x00). The sequence pushes the program counter and the status byte onto a stack in memory page 0x01. It then reads a 16-bit vector from the top of the address space and loads it into the program counter.

Reset has no sequence of its own. A reset-pending flag is set while reset is held. While the flag is set, the instruction register is forced to the break opcode and every stack write is suppressed. The vector is taken from 0xFFFC/0xFFFD instead of 0xFFFE/0xFFFF. The flag clears itself on the last cycle of that sequence. The stack pointer still steps down by three during reset, even though nothing is written.

The block drives a synchronous memory port. Read data returns one cycle after the address. Normal instruction decoding lies outside the block: an opcode is only latched into the instruction register. Opcode 0x00 is the one value that triggers the sequence.

Top module: `brkseq_top`

## Requirements
- R1: While `rst` is high, all registers clear: `pc`=0, `sp`=0, `status`=0, `ir`=0, `busy`=0. After release, the reset sequence starts on its own. Throughout it `ir` reads 0x00, whatever `op_byte` and `op_valid` carry.
- R2: During the reset sequence, `mem_we` is never asserted.
- R3: The reset sequence reads address 0xFFFC (low byte) and then 0xFFFD (high byte). It ends with `pc` = {high, low}.
- R4: The reset-pending state clears at the end of the sequence. With no requests, the block then stays idle and `pc` holds.
- R5: Opcode 0x00 with `op_valid`, while idle, starts a break. It writes the PC high byte to 0x0100+SP, the PC low byte to 0x0100+SP-1, and the status byte to 0x0100+SP-2. The pushed status byte has bit 4 (break) and bit 5 set.
- R6: `irq_req` while idle starts the same sequence. The pushed status byte has bit 4 clear and bit 5 set. Both the interrupt and the break load `pc` from 0xFFFE (low) and 0xFFFF (high).
- R7: Each push lowers `sp` by one, modulo 256, so each sequence lowers it by three. This includes reset, so `sp` is 0xFD after reset. Pushes that cross below 0x00 wrap to 0x01FF.
- R8: Status bit 2 (interrupt disable) is set by every sequence.
- R9: A sequence lasts exactly 7 cycles of `busy`. `done` is high in the seventh cycle only.
- R10: A nonzero opcode with `op_valid`, while idle, is loaded into `ir`. It starts no sequence and causes no write.
- R11: Priority among start causes is pending reset, then `irq_req`, then the break opcode. When an interrupt and a break opcode arrive together, the interrupt form is pushed.
- R12: Asserting `rst` in the middle of a sequence aborts it. The following reset sequence performs no writes and ends with the reset vector in `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; sets the reset-pending state |
| op_valid | input | 1 | Fetched opcode present on `op_byte` |
| op_byte | input | 8 | Fetched opcode |
| irq_req | input | 1 | Hardware interrupt request, level |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status register |
| ir | output | 8 | Instruction register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final cycle of the sequence |

## Verification
Some internal faults surface within a single sequence. A stuck reset-pending state shows on the next break as missing stack writes and as the reset vector in `pc`. A step counter off by one shows as a `busy` length other than seven, or as `done` on the wrong cycle. A wrong stack adder shows after one sequence as `sp` not lowered by three, or as bytes at the wrong stack addresses. A swapped break/interrupt source shows in bit 4 of the third pushed byte. Wrap faults are driven out by running interrupts until the pushes cross address 0x0100.

// File: rtl/brkseq_pkg.sv
`timescale 1ns/1ps
package brkseq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_LOAD    = 3'd1,
    SQ_PUSH_HI = 3'd2,
    SQ_PUSH_LO = 3'd3,
    SQ_PUSH_P  = 3'd4,
    SQ_VEC_LO  = 3'd5,
    SQ_VEC_HI  = 3'd6,
    SQ_FINISH  = 3'd7
  } sq_e;

  typedef enum logic [1:0] {
    SRC_RESET = 2'd0,
    SRC_IRQ   = 2'd1,
    SRC_BRK   = 2'd2
  } src_e;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;

  function automatic logic [DATA_W-1:0] push_status(input logic [DATA_W-1:0] p,
                                                     input src_e src);
    logic [DATA_W-1:0] v;
    v = p;
    v[FLAG_U] = 1'b1;
    v[FLAG_B] = (src == SRC_BRK);
    return v;
  endfunction
endpackage

// File: rtl/brkseq_rst_latch.sv
`timescale 1ns/1ps
module brkseq_rst_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)      pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end

  a_r1_pend_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pend);
  a_r4_pend_clears: assert property (@(posedge clk) disable iff (rst)
    clr |=> !pend);
endmodule

// File: rtl/brkseq_sp.sv
`timescale 1ns/1ps
module brkseq_sp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dec,
  output logic [W-1:0] sp
);
  localparam logic [W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (rst)      sp <= '0;
    else if (dec) sp <= sp + ALL_ONES;
  end

  a_r7_sp_step: assert property (@(posedge clk) disable iff (rst)
    dec |=> sp == W'($past(sp) - 1));
  a_r7_sp_hold: assert property (@(posedge clk) disable iff (rst)
    !dec |=> $stable(sp));
endmodule

// File: rtl/brkseq_ctrl.sv
`timescale 1ns/1ps
module brkseq_ctrl
  import brkseq_pkg::*;
#(
  parameter logic [DATA_W-1:0] BRK_OP = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend,
  input  logic              irq_req,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] op_byte,
  output sq_e               state,
  output src_e              src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      src   <= SRC_RESET;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (pend) begin
            state <= SQ_LOAD;
            src   <= SRC_RESET;
          end else if (irq_req) begin
            state <= SQ_LOAD;
            src   <= SRC_IRQ;
          end else if (op_valid && op_byte == BRK_OP) begin
            state <= SQ_LOAD;
            src   <= SRC_BRK;
          end
        end
        SQ_FINISH: state <= SQ_IDLE;
        default:   state <= sq_e'(state + 3'd1);
      endcase
    end
  end

  a_r9_steps_advance: assert property (@(posedge clk) disable iff (rst)
    (state != SQ_IDLE && state != SQ_FINISH) |=> state == sq_e'($past(state) + 3'd1));
  a_r9_finish_to_idle: assert property (@(posedge clk) disable iff (rst)
    state == SQ_FINISH |=> state == SQ_IDLE);
  a_r11_reset_first: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && pend) |=> (state == SQ_LOAD && src == SRC_RESET));
  a_r11_irq_over_brk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && !pend && irq_req) |=> src == SRC_IRQ);
endmodule

// File: rtl/brkseq_top.sv
`timescale 1ns/1ps
module brkseq_top
  import brkseq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] RST_VEC    = 16'hFFFC,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE,
  parameter logic [7:0]  BRK_OP     = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        op_valid,
  input  logic [7:0]  op_byte,
  input  logic        irq_req,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic [7:0]  status,
  output logic [7:0]  ir,
  output logic        busy,
  output logic        done
);
  sq_e  state;
  src_e src;
  logic pend;
  logic push_cyc;
  logic [DATA_W-1:0] vec_lo;
  logic [ADDR_W-1:0] vec_base;

  brkseq_rst_latch u_latch (
    .clk  (clk),
    .rst  (rst),
    .clr  (state == SQ_FINISH),
    .pend (pend)
  );

  brkseq_ctrl #(.BRK_OP(BRK_OP)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend),
    .irq_req  (irq_req),
    .op_valid (op_valid),
    .op_byte  (op_byte),
    .state    (state),
    .src      (src)
  );

  assign push_cyc = (state == SQ_PUSH_HI) || (state == SQ_PUSH_LO) || (state == SQ_PUSH_P);

  brkseq_sp #(.W(DATA_W)) u_sp (
    .clk (clk),
    .rst (rst),
    .dec (push_cyc),
    .sp  (sp)
  );

  assign vec_base = (src == SRC_RESET) ? RST_VEC : IRQ_VEC;

  // Memory port decoded from the step register
  always_comb begin
    mem_addr  = pc;
    mem_wdata = '0;
    mem_we    = 1'b0;
    case (state)
      SQ_PUSH_HI: begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wdata = pc[15:8];
        mem_we    = !pend;
      end
      SQ_PUSH_LO: begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wdata = pc[7:0];
        mem_we    = !pend;
      end
      SQ_PUSH_P: begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wdata = push_status(status, src);
        mem_we    = !pend;
      end
      SQ_VEC_LO: mem_addr = vec_base;
      SQ_VEC_HI: mem_addr = vec_base | 16'h0001;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir     <= '0;
      pc     <= '0;
      status <= '0;
      vec_lo <= '0;
    end else begin
      if (state == SQ_IDLE) begin
        if (pend || irq_req) ir <= BRK_OP;
        else if (op_valid)   ir <= op_byte;
      end
      if (state == SQ_PUSH_P) status[FLAG_I] <= 1'b1;
      if (state == SQ_VEC_HI) vec_lo <= mem_rdata;
      if (state == SQ_FINISH) pc <= {mem_rdata, vec_lo};
    end
  end

  assign busy = (state != SQ_IDLE);
  assign done = (state == SQ_FINISH);

  a_r2_no_write_in_reset: assert property (@(posedge clk) disable iff (rst)
    (busy && src == SRC_RESET) |-> !mem_we);
  a_r1_ir_forced: assert property (@(posedge clk) disable iff (rst)
    (busy && src == SRC_RESET) |-> ir == BRK_OP);
  a_r3_reset_vector: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_VEC_LO && src == SRC_RESET) |-> mem_addr == RST_VEC);
  a_r5_break_flag_set: assert property (@(posedge clk) disable iff (rst)
    (mem_we && state == SQ_PUSH_P && src == SRC_BRK) |-> mem_wdata[FLAG_B]);
  a_r6_break_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (mem_we && state == SQ_PUSH_P && src == SRC_IRQ) |-> !mem_wdata[FLAG_B]);
  a_r8_idisable_set: assert property (@(posedge clk) disable iff (rst)
    state == SQ_PUSH_P |=> status[FLAG_I]);
  a_r10_plain_opcode: assert property (@(posedge clk) disable iff (rst)
    (!busy && !pend && !irq_req && op_valid && op_byte != BRK_OP)
      |=> (!busy && ir == $past(op_byte)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/sim_brkseq_top.sv
`timescale 1ns/1ps
module sim_brkseq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = 8'h00;
  logic        irq_req = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [15:0] pc;
  logic [7:0]  sp;
  logic [7:0]  status;
  logic [7:0]  ir;
  logic        busy;
  logic        done;

  int errors = 0;
  int checks = 0;

  logic [7:0] stk [256];
  logic [15:0] rv = 16'hC0DE;
  logic [15:0] iv = 16'hBEEF;
  int wr_cnt = 0;

  always #4 clk = ~clk;

  brkseq_top u0 (.*);

  // memory model: one-cycle read latency, stack page writes
  always @(posedge clk) begin
    if (mem_we) begin
      wr_cnt <= wr_cnt + 1;
      if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    end
    case (mem_addr)
      16'hFFFC: mem_rdata <= rv[7:0];
      16'hFFFD: mem_rdata <= rv[15:8];
      16'hFFFE: mem_rdata <= iv[7:0];
      16'hFFFF: mem_rdata <= iv[15:8];
      default:  mem_rdata <= 8'h00;
    endcase
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // waits through a sequence that starts at the next edge
  task automatic run_seq(output int ncyc, output int done_at, output int ndone,
                         output int nwe, output int ir_bad);
    ncyc = 0; done_at = 0; ndone = 0; nwe = 0; ir_bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
      irq_req  = 1'b0;
      if (busy) begin
        ncyc++;
        if (done) begin ndone++; done_at = ncyc; end
        if (mem_we) nwe++;
        if (ir !== 8'h00) ir_bad++;
      end else if (ncyc > 0) begin
        break;
      end
    end
  endtask

  task automatic t_reset;
    int n, da, nd, nw, ib;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "pc after reset", pc, 16'h0000);
    chk("R1", "sp after reset", sp, 8'h00);
    chk("R1", "status after reset", status, 8'h00);
    chk("R1", "ir after reset", ir, 8'h00);
    chk("R1", "busy after reset", busy, 1'b0);
    op_valid = 1'b1; op_byte = 8'hEA;
    rst = 1'b0;
    run_seq(n, da, nd, nw, ib);
    op_valid = 1'b0;
    chk("R1", "ir forced to 00 during reset sequence", ib, 0);
    chk("R2", "writes during reset sequence", nw, 0);
    chk("R3", "pc from reset vector", pc, 16'hC0DE);
    chk("R7", "sp after reset sequence", sp, 8'hFD);
    chk("R8", "I flag after reset", status[2], 1'b1);
    chk("R9", "reset sequence length", n, 7);
    chk("R9", "done cycle", da, 7);
    chk("R9", "done pulses", nd, 1);
  endtask

  task automatic t_idle_after_reset;
    int seen = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk("R4", "busy cycles after reset completed", seen, 0);
    chk("R4", "pc holds in idle", pc, 16'hC0DE);
  endtask

  task automatic t_brk;
    int n, da, nd, nw, ib, w0;
    w0 = wr_cnt;
    op_valid = 1'b1; op_byte = 8'h00;
    run_seq(n, da, nd, nw, ib);
    chk("R5", "brk writes", nw, 3);
    chk("R5", "pushed pc high at 01FD", stk[8'hFD], 8'hC0);
    chk("R5", "pushed pc low at 01FC", stk[8'hFC], 8'hDE);
    chk("R5", "pushed status at 01FB", stk[8'hFB], 8'h34);
    chk("R6", "pc from brk vector", pc, 16'hBEEF);
    chk("R7", "sp after brk", sp, 8'hFA);
    chk("R9", "brk length", n, 7);
    chk("R9", "brk done cycle", da, 7);
    chk("R4", "writes in memory model", wr_cnt - w0, 3);
  endtask

  task automatic t_irq;
    int n, da, nd, nw, ib;
    iv = 16'h4455;
    irq_req = 1'b1;
    run_seq(n, da, nd, nw, ib);
    chk("R6", "irq pushed pc high", stk[8'hFA], 8'hBE);
    chk("R6", "irq pushed pc low", stk[8'hF9], 8'hEF);
    chk("R6", "irq pushed status B clear", stk[8'hF8], 8'h24);
    chk("R6", "pc from irq vector", pc, 16'h4455);
    chk("R7", "sp after irq", sp, 8'hF7);
  endtask

  task automatic t_priority;
    int n, da, nd, nw, ib;
    irq_req = 1'b1; op_valid = 1'b1; op_byte = 8'h00;
    run_seq(n, da, nd, nw, ib);
    chk("R11", "status pushed by irq beats brk", stk[8'hF5], 8'h24);
    chk("R11", "writes", nw, 3);
    chk("R7", "sp after priority case", sp, 8'hF4);
  endtask

  task automatic t_plain_op;
    int w0, seen;
    w0 = wr_cnt; seen = 0;
    op_valid = 1'b1; op_byte = 8'hA9;
    @(negedge clk);
    op_valid = 1'b0;
    if (busy) seen++;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk("R10", "ir loaded", ir, 8'hA9);
    chk("R10", "no sequence", seen, 0);
    chk("R10", "no writes", wr_cnt - w0, 0);
    chk("R10", "sp unchanged", sp, 8'hF4);
  endtask

  task automatic t_wrap;
    int n, da, nd, nw, ib;
    for (int k = 0; k < 100 && sp != 8'h01; k++) begin
      irq_req = 1'b1;
      run_seq(n, da, nd, nw, ib);
    end
    chk("R7", "sp reached 01", sp, 8'h01);
    irq_req = 1'b1;
    run_seq(n, da, nd, nw, ib);
    chk("R7", "pc high at 0101", stk[8'h01], 8'h44);
    chk("R7", "pc low at 0100", stk[8'h00], 8'h55);
    chk("R7", "status wrapped to 01FF", stk[8'hFF], 8'h24);
    chk("R7", "sp after wrap", sp, 8'hFE);
  endtask

  task automatic t_mid_reset;
    int n, da, nd, nw, ib, w0;
    op_valid = 1'b1; op_byte = 8'h00;
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12", "busy cleared by reset", busy, 1'b0);
    w0 = wr_cnt;
    op_valid = 1'b1; op_byte = 8'hEA;
    rst = 1'b0;
    run_seq(n, da, nd, nw, ib);
    op_valid = 1'b0;
    chk("R12", "writes after abort", wr_cnt - w0, 0);
    chk("R12", "pc from reset vector", pc, 16'hC0DE);
    chk("R12", "sp after aborted sequence", sp, 8'hFD);
    chk("R1", "ir forced after abort", ib, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    t_reset();
    t_idle_after_reset();
    t_brk();
    t_irq();
    t_priority();
    t_plain_op();
    t_wrap();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule